// File: doc/BRIEF.md
# Board Self-Test Sequencer with Signature Compare

This block runs the power-on self-test of a multi-chip board. It waits until the supply and the clock are reported good. It then drives a command bus that every chip on the board listens to. Its first broadcast command tells all chips to turn off their three-state output drivers, so that each chip is electrically isolated from its neighbours. The block then runs five test phases in a fixed order: test-port setup, embedded-memory initialisation, embedded-memory test, DC logic self-test and AC logic self-test.

Each phase works the same way. The block broadcasts a 31-bit seed and then a start command. It waits a programmed number of cycles while the chips compress their test responses. It then polls every chip by address, one at a time, and compares the 31-bit signature that comes back with an expected value from a constant table. Seeds, expected signatures and run lengths all come from that table.

When every signature in every phase matches, the block releases the system from reset. At the first mismatch it stops issuing commands. It raises a fail flag and holds an error code that names the phase and the chip. Both the flag and the code stay set until the next reset.

Top module: `stest_seq`

## Requirements
- R1: While `rst_n` is low and in the first cycle after reset, `cmd_valid`, `sys_rel` and `fail` are 0 and `err_code` is 0.
- R2: No command is issued until `pwr_good` and `clk_stable` are both high on the same clock edge. Either input high on its own starts nothing.
- R3: The first command is a single broadcast isolate command: `cmd_op` = 1, `cmd_bcast` = 1.
- R4: The phases run in the order 0, 1, 2, 3, 4. Each phase p starts with a broadcast seed command (`cmd_op` = 2). Its `cmd_data` is bits 30:0 of the 32-bit product (p+1)·0x1B873593.
- R5: After the seed comes a broadcast run command (`cmd_op` = 3). The first poll of the phase follows exactly RUN_BASE + p·RUN_STEP + 1 cycles after the run command. No command is issued in between.
- R6: Each poll is an addressed command: `cmd_op` = 4, `cmd_bcast` = 0, chip number on `cmd_addr`. Chips are polled in ascending order from 0 to N_CHIP-1. Only one poll is outstanding at a time. No new command is issued before `rsp_valid` answers the current poll. A `rsp_valid` pulse that arrives while no poll is outstanding is ignored.
- R7: The expected signature for phase p and chip c is bits 30:0 of the 32-bit product (16·p + c + 1)·0x2545F491. If every poll of every phase matches, `sys_rel` rises one cycle after the last response and stays high. No further command is issued, and `fail` stays 0.
- R8: At the first mismatching response, `fail` rises one cycle later. `err_code` then holds {phase[2:0], chip[3:0]}, with the phase in bits 6:4. No further command is issued, and `sys_rel` stays 0.
- R9: Once set, `fail` and `err_code` do not change until `rst_n` is asserted, even if more responses arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good | input | 1 | Supply voltage reported stable |
| clk_stable | input | 1 | System clock reported stable |
| cmd_valid | output | 1 | A command is on the bus this cycle |
| cmd_op | output | 3 | Command code: 1 isolate, 2 seed, 3 run, 4 poll |
| cmd_bcast | output | 1 | 1 when the command goes to every chip |
| cmd_addr | output | 4 | Target chip of an addressed command |
| cmd_data | output | 31 | Seed value carried by a seed command |
| rsp_valid | input | 1 | Polled chip presents its signature |
| rsp_sig | input | 31 | Signature returned by the polled chip |
| sys_rel | output | 1 | System reset released, self-test passed |
| fail | output | 1 | Sticky self-test failure flag |
| err_code | output | 7 | Failing phase (bits 6:4) and chip (bits 3:0) |

## Verification
Most wrong internal states show up at the ports within one command. A phase counter that is off shows up on the next seed word. A chip counter that is off shows up on the next poll address. A run timer that is off shows up as a gap of the wrong length between the run command and the first poll.

A compare or error register that is off appears one cycle after the response it judged. It shows either as `fail` rising on a good signature or as a wrong `err_code`.

A sequencer that wrongly accepts a response with no poll outstanding skips a chip. That skip shows in the poll address that comes right after the response.

// File: rtl/stest_pkg.sv
package stest_pkg;
  localparam int SIG_W   = 31;
  localparam int PH_W    = 3;
  localparam int CHIP_W  = 4;
  localparam int OP_W    = 3;
  localparam int N_PHASE = 5;
  localparam int ERR_W   = PH_W + CHIP_W;

  typedef enum logic [OP_W-1:0] {
    OP_NOP     = 3'd0,
    OP_ISOLATE = 3'd1,
    OP_SEED    = 3'd2,
    OP_RUN     = 3'd3,
    OP_POLL    = 3'd4
  } op_e;

  typedef enum logic [3:0] {
    S_WAIT = 4'd0,
    S_ISO  = 4'd1,
    S_SEED = 4'd2,
    S_GO   = 4'd3,
    S_RUN  = 4'd4,
    S_POLL = 4'd5,
    S_WRSP = 4'd6,
    S_PASS = 4'd7,
    S_FAIL = 4'd8
  } st_e;

  function automatic logic [SIG_W-1:0] seed_of(input logic [PH_W-1:0] p);
    logic [31:0] t;
    t = ({29'd0, p} + 32'd1) * 32'h1B873593;
    return t[SIG_W-1:0];
  endfunction

  function automatic logic [SIG_W-1:0] golden_of(input logic [PH_W-1:0] p,
                                                 input logic [CHIP_W-1:0] c);
    logic [31:0] t;
    t = ({25'd0, p, c} + 32'd1) * 32'h2545F491;
    return t[SIG_W-1:0];
  endfunction
endpackage

// File: rtl/stest_table.sv
module stest_table
  import stest_pkg::*;
#(
  parameter int RUN_BASE = 8,
  parameter int RUN_STEP = 4,
  parameter int RUN_W    = 5
) (
  input  logic [PH_W-1:0]   phase,
  input  logic [CHIP_W-1:0] chip,
  output logic [SIG_W-1:0]  seed,
  output logic [SIG_W-1:0]  golden,
  output logic [RUN_W-1:0]  run_len
);
  logic [SIG_W-1:0] seed_tab [N_PHASE];
  logic [RUN_W-1:0] run_tab  [N_PHASE];

  generate
    for (genvar g = 0; g < N_PHASE; g++) begin : g_ph
      assign seed_tab[g] = seed_of(PH_W'(g));
      assign run_tab[g]  = RUN_W'(RUN_BASE + g * RUN_STEP);
    end
  endgenerate

  always_comb begin
    seed    = '0;
    run_len = '0;
    for (int k = 0; k < N_PHASE; k++) begin
      if (phase == PH_W'(k)) begin
        seed    = seed_tab[k];
        run_len = run_tab[k];
      end
    end
  end

  assign golden = golden_of(phase, chip);
endmodule

// File: rtl/stest_runtimer.sv
module stest_runtimer #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] len,
  input  logic         en,
  output logic         last
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = len;
    end else if (en && cnt_q != '0) begin
      cnt_d = cnt_q - W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign last = (cnt_q == W'(1));

  // R5
  run_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(len)));

  // R5
  run_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - W'(1)));
endmodule

// File: rtl/stest_check.sv
module stest_check
  import stest_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample,
  input  logic [SIG_W-1:0]  sig,
  input  logic [SIG_W-1:0]  golden,
  input  logic [PH_W-1:0]   phase,
  input  logic [CHIP_W-1:0] chip,
  output logic              match,
  output logic              fail,
  output logic [ERR_W-1:0]  err_code
);
  logic             fail_d;
  logic [ERR_W-1:0] err_d;
  logic             trip;

  assign match = (sig == golden);
  assign trip  = sample && !match && !fail;

  always_comb begin
    fail_d = fail;
    err_d  = err_code;
    if (trip) begin
      fail_d = 1'b1;
      err_d  = {phase, chip};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail     <= 1'b0;
      err_code <= '0;
    end else begin
      fail     <= fail_d;
      err_code <= err_d;
    end
  end

  // R9
  fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail |=> fail);

  // R9
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail |=> $stable(err_code));

  // R8
  fail_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail) |-> $past(sample));
endmodule

// File: rtl/stest_seq.sv
module stest_seq
  import stest_pkg::*;
#(
  parameter int N_CHIP   = 6,
  parameter int RUN_BASE = 8,
  parameter int RUN_STEP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_good,
  input  logic              clk_stable,
  output logic              cmd_valid,
  output logic [OP_W-1:0]   cmd_op,
  output logic              cmd_bcast,
  output logic [CHIP_W-1:0] cmd_addr,
  output logic [SIG_W-1:0]  cmd_data,
  input  logic              rsp_valid,
  input  logic [SIG_W-1:0]  rsp_sig,
  output logic              sys_rel,
  output logic              fail,
  output logic [ERR_W-1:0]  err_code
);
  localparam int RUN_MAX = RUN_BASE + (N_PHASE - 1) * RUN_STEP;
  localparam int RUN_W   = $clog2(RUN_MAX + 1);
  localparam logic [CHIP_W-1:0] LAST_CHIP = CHIP_W'(N_CHIP - 1);
  localparam logic [PH_W-1:0]   LAST_PH   = PH_W'(N_PHASE - 1);

  st_e               state_q, state_d;
  logic [PH_W-1:0]   phase_q, phase_d;
  logic [CHIP_W-1:0] chip_q, chip_d;

  logic [SIG_W-1:0]  seed_w;
  logic [SIG_W-1:0]  golden_w;
  logic [RUN_W-1:0]  run_len_w;
  logic              run_last;
  logic              sig_match;
  logic              take_rsp;

  stest_table #(
    .RUN_BASE (RUN_BASE),
    .RUN_STEP (RUN_STEP),
    .RUN_W    (RUN_W)
  ) u_table (
    .phase   (phase_q),
    .chip    (chip_q),
    .seed    (seed_w),
    .golden  (golden_w),
    .run_len (run_len_w)
  );

  stest_runtimer #(
    .W (RUN_W)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (state_q == S_GO),
    .len   (run_len_w),
    .en    (state_q == S_RUN),
    .last  (run_last)
  );

  assign take_rsp = (state_q == S_WRSP) && rsp_valid;

  stest_check u_check (
    .clk      (clk),
    .rst_n    (rst_n),
    .sample   (take_rsp),
    .sig      (rsp_sig),
    .golden   (golden_w),
    .phase    (phase_q),
    .chip     (chip_q),
    .match    (sig_match),
    .fail     (fail),
    .err_code (err_code)
  );

  always_comb begin
    state_d = state_q;
    phase_d = phase_q;
    chip_d  = chip_q;
    unique case (state_q)
      S_WAIT: if (pwr_good && clk_stable) state_d = S_ISO;
      S_ISO: begin
        phase_d = '0;
        chip_d  = '0;
        state_d = S_SEED;
      end
      S_SEED: begin
        chip_d  = '0;
        state_d = S_GO;
      end
      S_GO:   state_d = S_RUN;
      S_RUN:  if (run_last) state_d = S_POLL;
      S_POLL: state_d = S_WRSP;
      S_WRSP: begin
        if (rsp_valid) begin
          if (!sig_match) begin
            state_d = S_FAIL;
          end else if (chip_q != LAST_CHIP) begin
            chip_d  = chip_q + CHIP_W'(1);
            state_d = S_POLL;
          end else if (phase_q != LAST_PH) begin
            phase_d = phase_q + PH_W'(1);
            chip_d  = '0;
            state_d = S_SEED;
          end else begin
            state_d = S_PASS;
          end
        end
      end
      S_PASS: state_d = S_PASS;
      S_FAIL: state_d = S_FAIL;
      default: state_d = S_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_WAIT;
      phase_q <= '0;
      chip_q  <= '0;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
      chip_q  <= chip_d;
    end
  end

  always_comb begin
    cmd_valid = 1'b0;
    cmd_op    = OP_NOP;
    cmd_bcast = 1'b0;
    cmd_addr  = '0;
    cmd_data  = '0;
    unique case (state_q)
      S_ISO: begin
        cmd_valid = 1'b1;
        cmd_op    = OP_ISOLATE;
        cmd_bcast = 1'b1;
      end
      S_SEED: begin
        cmd_valid = 1'b1;
        cmd_op    = OP_SEED;
        cmd_bcast = 1'b1;
        cmd_data  = seed_w;
      end
      S_GO: begin
        cmd_valid = 1'b1;
        cmd_op    = OP_RUN;
        cmd_bcast = 1'b1;
      end
      S_POLL: begin
        cmd_valid = 1'b1;
        cmd_op    = OP_POLL;
        cmd_addr  = chip_q;
      end
      default: ;
    endcase
  end

  assign sys_rel = (state_q == S_PASS);

  // R6
  addr_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_bcast) |-> (cmd_op == OP_POLL));

  // R7
  pass_fail_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sys_rel && fail));

  // R7
  rel_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rel |=> sys_rel);

  // R7
  rel_after_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rel) |-> $past(rsp_valid));

  // R8
  halt_on_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> !cmd_valid);

  // R6
  single_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_POLL) |=> !cmd_valid);
endmodule

// File: tb/stest_seq_tb.sv
module stest_seq_tb;
  localparam int CLK_PER  = 10;
  localparam int N_CHIP   = 6;
  localparam int RUN_BASE = 8;
  localparam int RUN_STEP = 4;

  logic        clk;
  logic        rst_n;
  logic        pwr_good;
  logic        clk_stable;
  logic        cmd_valid;
  logic [2:0]  cmd_op;
  logic        cmd_bcast;
  logic [3:0]  cmd_addr;
  logic [30:0] cmd_data;
  logic        rsp_valid;
  logic [30:0] rsp_sig;
  logic        sys_rel;
  logic        fail;
  logic [6:0]  err_code;

  int total = 0;
  int bad   = 0;

  stest_seq #(
    .N_CHIP   (N_CHIP),
    .RUN_BASE (RUN_BASE),
    .RUN_STEP (RUN_STEP)
  ) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr_good   (pwr_good),
    .clk_stable (clk_stable),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .cmd_bcast  (cmd_bcast),
    .cmd_addr   (cmd_addr),
    .cmd_data   (cmd_data),
    .rsp_valid  (rsp_valid),
    .rsp_sig    (rsp_sig),
    .sys_rel    (sys_rel),
    .fail       (fail),
    .err_code   (err_code)
  );

  initial clk = 1'b0;
  always #(CLK_PER / 2) clk = ~clk;

  function automatic logic [30:0] exp_seed(input int p);
    logic [31:0] t;
    t = 32'(p + 1) * 32'h1B873593;
    return t[30:0];
  endfunction

  function automatic logic [30:0] exp_gold(input int p, input int c);
    logic [31:0] t;
    t = 32'(p * 16 + c + 1) * 32'h2545F491;
    return t[30:0];
  endfunction

  function automatic int exp_run(input int p);
    return RUN_BASE + p * RUN_STEP;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n      = 1'b0;
    pwr_good   = 1'b0;
    clk_stable = 1'b0;
    rsp_valid  = 1'b0;
    rsp_sig    = '0;
    repeat (3) @(negedge clk);
    chk(!cmd_valid && !sys_rel && !fail && err_code == 7'd0, "R1 reset state",
        {cmd_valid, sys_rel, fail, err_code}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!cmd_valid && !sys_rel && !fail && err_code == 7'd0, "R1 after release",
        {cmd_valid, sys_rel, fail, err_code}, 32'd0);
  endtask

  // fp < 0: all chips good
  task automatic run_seq(input int fp, input int fc, input bit stray);
    int stage = 0;
    int ep = 0;
    int ec = 0;
    int pc = 0;
    int tg = 0;
    int cyc = 0;
    int pending = 0;
    int gate;
    bit cmd_early = 0;
    logic [30:0] badsig;

    do_reset();
    gate = 3 + int'($urandom % 6);
    if ($urandom % 2 == 0) pwr_good = 1'b1; else clk_stable = 1'b1;
    for (int i = 0; i < gate; i++) begin
      @(negedge clk);
      if (cmd_valid) cmd_early = 1;
    end
    chk(!cmd_early, "R2 one start input only", 32'(cmd_early), 32'd0);
    pwr_good   = 1'b1;
    clk_stable = 1'b1;

    while (!sys_rel && !fail && cyc < 5000) begin
      @(negedge clk);
      cyc++;
      if (rsp_valid) rsp_valid = 1'b0;
      if (pending > 0) begin
        pending--;
        if (pending == 0) begin
          rsp_valid = 1'b1;
          if (ep == fp && pc == fc) begin
            badsig  = exp_gold(ep, pc) ^ (31'd1 << ($urandom % 31));
            rsp_sig = badsig;
            stage   = 5;
          end else begin
            rsp_sig = exp_gold(ep, pc);
            ec++;
            if (ec == N_CHIP) begin
              ec = 0;
              ep++;
              stage = (ep == 5) ? 6 : 1;
            end else begin
              stage = 3;
            end
          end
        end
      end
      if (cmd_valid) begin
        case (stage)
          0: begin
            chk(cmd_op == 3'd1 && cmd_bcast, "R3 first cmd isolate",
                {cmd_bcast, cmd_op}, 32'h9);
            stage = 1;
          end
          1: begin
            chk(cmd_op == 3'd2 && cmd_bcast && cmd_data == exp_seed(ep),
                "R4 seed cmd/value", {cmd_op, cmd_data}, {3'd2, exp_seed(ep)});
            stage = 2;
          end
          2: begin
            chk(cmd_op == 3'd3 && cmd_bcast, "R5 run cmd", {cmd_bcast, cmd_op}, 32'hB);
            tg = cyc;
            stage = 3;
            if (stray) begin
              rsp_valid = 1'b1;
              rsp_sig   = ~exp_gold(ep, 0);
            end
          end
          3: begin
            chk(cmd_op == 3'd4 && !cmd_bcast && cmd_addr == 4'(ec),
                "R6 poll cmd/address", {cmd_bcast, cmd_op, cmd_addr},
                {1'b0, 3'd4, 4'(ec)});
            if (ec == 0)
              chk(cyc - tg == exp_run(ep) + 1, "R5 run length",
                  32'(cyc - tg), 32'(exp_run(ep) + 1));
            pc = ec;
            pending = 1 + int'($urandom % 3);
            stage = 4;
          end
          default: chk(1'b0, "R6 R7 R8 unexpected command", {cmd_op, cmd_addr}, 32'd0);
        endcase
      end
    end
    chk(cyc < 5000, "R7 sequence ended", 32'(cyc), 32'd5000);
    rsp_valid = 1'b0;

    if (fp >= 0) begin
      chk(fail && !sys_rel, "R8 fail flag", {sys_rel, fail}, 32'h1);
      chk(err_code == {3'(fp), 4'(fc)}, "R8 error code", err_code, {3'(fp), 4'(fc)});
      @(negedge clk);
      rsp_valid = 1'b1;
      rsp_sig   = exp_gold(fp, fc);
      cmd_early = 0;
      for (int i = 0; i < 10; i++) begin
        @(negedge clk);
        rsp_valid = 1'b0;
        if (cmd_valid || !fail || sys_rel) cmd_early = 1;
      end
      chk(!cmd_early && err_code == {3'(fp), 4'(fc)}, "R9 sticky after more responses",
          err_code, {3'(fp), 4'(fc)});
    end else begin
      chk(sys_rel && !fail && ep == 5, "R7 release after all phases",
          {sys_rel, fail, 5'(ep)}, {1'b1, 1'b0, 5'd5});
      cmd_early = 0;
      for (int i = 0; i < 10; i++) begin
        @(negedge clk);
        if (cmd_valid || !sys_rel) cmd_early = 1;
      end
      chk(!cmd_early, "R7 stays released, bus idle", 32'(cmd_early), 32'd0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    run_seq(-1, -1, 1'b0);
    run_seq(-1, -1, 1'b1);
    run_seq(0, 0, 1'b0);
    run_seq(4, N_CHIP - 1, 1'b0);
    for (int t = 0; t < 6; t++) begin
      run_seq(int'($urandom % 5), int'($urandom % N_CHIP), 1'($urandom % 2));
    end
    run_seq(-1, -1, 1'b1);
    do_reset();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule